// File: doc/BRIEF.md
# Dual-Lane Shift-Mask-Add Interpolator

This block is a small arithmetic engine that a processor drives through a simple register bus. It holds two 32-bit accumulators, three base registers and two lane control words. Each lane takes an accumulator, shifts it right and keeps a contiguous bit field. It can sign-extend that field, and it adds the field to its base to form a lane result. A third, combined result adds the high base to both lanes' fields. Typical use is walking tables or generating address sequences: software reads a result through a side-effect-free peek address, or through a pop address that also loads the results back into the accumulators.

Each lane can be rewired. It can take the other lane's accumulator as its input, or load the other lane's result on a pop. It can bypass shift and mask for its own result while the combined result keeps the masked value. It can force two high bits of the value the bus sees, without touching the value that is written back.

Top module: `interp_unit`

## Requirements
- R1: After reset every accumulator, base and control register is zero, so every readable address returns zero.
- R2: Word address map (4-bit): 0 ACC0, 1 ACC1, 2 BASE0, 3 BASE1, 4 BASE2, 5 CTRL0, 6 CTRL1, 8 PEEK0, 9 PEEK1, 10 PEEKF, 12 POP0, 13 POP1, 14 POPF. A write to ACC, BASE or CTRL takes effect at the next clock edge. A write to any other address is ignored. Reads are combinational. Control reads return only bits 20:0, with the rest zero. Unmapped reads, and any cycle without a read, give zero on the read data.
- R3: Control word fields: shift amount [4:0], field low bound [9:5], field high bound [14:10], sign enable [15], cross input [16], cross result [17], raw add [18], forced bits [20:19]. A lane's field is its input shifted right logically by the shift amount, with only bits from the low bound up to the high bound, both ends inclusive, kept.
- R4: With sign enable set, the bits above the high bound copy the field bit at the high bound before the base is added, and peek/pop reads show this sign-extended sum.
- R5: When the high bound is below the low bound the field is zero, so the lane adds nothing.
- R6: With raw add set, the lane result is its base plus its unshifted, unmasked input. The combined result still uses the lane's field.
- R7: With cross input set, the lane's input is the other lane's accumulator, both for the field and for the raw-add path.
- R8: The combined result is BASE2 plus the field of lane 0 plus the field of lane 1, read at PEEKF.
- R9: A peek read changes no register.
- R10: A pop read of POP0 or POP1 returns the same value as the matching peek. At the next edge it loads both accumulators at once, each with its own lane result, or with the other lane's result when cross result is set, both taken from values before the update.
- R11: A pop at POPF returns the combined result and updates the accumulators as in R10.
- R12: The forced bits are ORed into bits 29:28 of the lane result only as read on the bus. The value written back on a pop is unforced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_valid | input | 1 | A bus access is present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data, zero when no read |

## Verification
The bench builds the block with its defaults: a 32-bit datapath, a 4-bit address and the forced bits at 29:28. Every shift amount from 0 to 31 and every pair of field bounds can therefore be reached, including inverted bounds and a field whose top is bit 31. With random control words the forced bits also meet carries out of the base addition. Random traffic mixes cross input, cross result, raw add and sign extension on both lanes at once, so pops with crossed write-back both ways, and back-to-back pops, come up often.

// File: rtl/interp_pkg.sv
package interp_pkg;

  localparam int IP_DATA_W = 32;
  localparam int IP_SEL_W  = 5;
  localparam int IP_ADDR_W = 4;

  // register addresses (word granularity)
  localparam logic [IP_ADDR_W-1:0] ADR_ACC0  = 4'h0;
  localparam logic [IP_ADDR_W-1:0] ADR_ACC1  = 4'h1;
  localparam logic [IP_ADDR_W-1:0] ADR_BASE0 = 4'h2;
  localparam logic [IP_ADDR_W-1:0] ADR_BASE1 = 4'h3;
  localparam logic [IP_ADDR_W-1:0] ADR_BASE2 = 4'h4;
  localparam logic [IP_ADDR_W-1:0] ADR_CTRL0 = 4'h5;
  localparam logic [IP_ADDR_W-1:0] ADR_CTRL1 = 4'h6;
  localparam logic [IP_ADDR_W-1:0] ADR_PEEK0 = 4'h8;
  localparam logic [IP_ADDR_W-1:0] ADR_PEEK1 = 4'h9;
  localparam logic [IP_ADDR_W-1:0] ADR_PEEKF = 4'hA;
  localparam logic [IP_ADDR_W-1:0] ADR_POP0  = 4'hC;
  localparam logic [IP_ADDR_W-1:0] ADR_POP1  = 4'hD;
  localparam logic [IP_ADDR_W-1:0] ADR_POPF  = 4'hE;

  // lane control word, LSB field last
  typedef struct packed {
    logic [1:0]          force_hi;
    logic                add_raw;
    logic                cross_res;
    logic                cross_in;
    logic                sign_en;
    logic [IP_SEL_W-1:0] msb;
    logic [IP_SEL_W-1:0] lsb;
    logic [IP_SEL_W-1:0] shamt;
  } ip_ctrl_t;

  localparam int IP_CTRL_W = $bits(ip_ctrl_t);

endpackage

// File: rtl/interp_rst_sync.sv
module interp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_ok = sync_q[STAGES-1];

endmodule

// File: rtl/interp_lane.sv
module interp_lane
  import interp_pkg::*;
#(
  parameter int DATA_W    = IP_DATA_W,
  parameter int FORCE_LSB = 28
) (
  input  ip_ctrl_t          ctrl,
  input  logic [DATA_W-1:0] acc_own,
  input  logic [DATA_W-1:0] acc_other,
  input  logic [DATA_W-1:0] base,
  output logic [DATA_W-1:0] contrib,
  output logic [DATA_W-1:0] result,
  output logic [DATA_W-1:0] bus_view
);

  localparam int SEL_W = IP_SEL_W;

  logic [DATA_W-1:0] src;
  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] fmask;
  logic [DATA_W-1:0] masked;
  logic              sign_bit;
  logic [DATA_W-1:0] addend;
  logic [DATA_W-1:0] forced;

  // input select sits ahead of the raw bypass
  assign src     = ctrl.cross_in ? acc_other : acc_own;
  assign shifted = src >> ctrl.shamt;

  // per-bit window compare and sign fill
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    localparam logic [SEL_W:0] IDX = (SEL_W+1)'(i);
    assign fmask[i]   = (IDX >= {1'b0, ctrl.lsb}) && (IDX <= {1'b0, ctrl.msb});
    assign contrib[i] = (IDX > {1'b0, ctrl.msb}) ? (ctrl.sign_en & sign_bit)
                                                  : masked[i];
  end

  assign masked   = shifted & fmask;
  assign sign_bit = masked[ctrl.msb];

  assign addend   = ctrl.add_raw ? src : contrib;
  assign result   = base + addend;

  assign forced   = DATA_W'(ctrl.force_hi) << FORCE_LSB;
  assign bus_view = result | forced;

endmodule

// File: rtl/interp_bus.sv
module interp_bus
  import interp_pkg::*;
#(
  parameter int DATA_W = IP_DATA_W,
  parameter int ADDR_W = IP_ADDR_W,
  parameter int CTRL_W = IP_CTRL_W
) (
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] acc0,
  input  logic [DATA_W-1:0] acc1,
  input  logic [DATA_W-1:0] base0,
  input  logic [DATA_W-1:0] base1,
  input  logic [DATA_W-1:0] base2,
  input  logic [CTRL_W-1:0] ctrl0,
  input  logic [CTRL_W-1:0] ctrl1,
  input  logic [DATA_W-1:0] view0,
  input  logic [DATA_W-1:0] view1,
  input  logic [DATA_W-1:0] full,
  output logic [1:0]        acc_we,
  output logic [2:0]        base_we,
  output logic [1:0]        ctrl_we,
  output logic              pop,
  output logic [DATA_W-1:0] rdata
);

  logic              wr;
  logic              rd;
  logic [DATA_W-1:0] sel;

  assign wr = bus_valid & bus_write;
  assign rd = bus_valid & ~bus_write;

  always_comb begin
    acc_we  = '0;
    base_we = '0;
    ctrl_we = '0;
    pop     = 1'b0;
    sel     = '0;
    unique case (bus_addr)
      ADDR_W'(ADR_ACC0):  begin acc_we[0]  = wr; sel = acc0;  end
      ADDR_W'(ADR_ACC1):  begin acc_we[1]  = wr; sel = acc1;  end
      ADDR_W'(ADR_BASE0): begin base_we[0] = wr; sel = base0; end
      ADDR_W'(ADR_BASE1): begin base_we[1] = wr; sel = base1; end
      ADDR_W'(ADR_BASE2): begin base_we[2] = wr; sel = base2; end
      ADDR_W'(ADR_CTRL0): begin ctrl_we[0] = wr; sel = DATA_W'(ctrl0); end
      ADDR_W'(ADR_CTRL1): begin ctrl_we[1] = wr; sel = DATA_W'(ctrl1); end
      ADDR_W'(ADR_PEEK0): sel = view0;
      ADDR_W'(ADR_PEEK1): sel = view1;
      ADDR_W'(ADR_PEEKF): sel = full;
      ADDR_W'(ADR_POP0):  begin pop = rd; sel = view0; end
      ADDR_W'(ADR_POP1):  begin pop = rd; sel = view1; end
      ADDR_W'(ADR_POPF):  begin pop = rd; sel = full;  end
      default:            sel = '0;
    endcase
  end

  assign rdata = rd ? sel : '0;

endmodule

// File: rtl/interp_unit.sv
module interp_unit
  import interp_pkg::*;
#(
  parameter int DATA_W    = IP_DATA_W,
  parameter int ADDR_W    = IP_ADDR_W,
  parameter int FORCE_LSB = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);

  localparam int LANES  = 2;
  localparam int BASES  = LANES + 1;
  localparam int CTRL_W = IP_CTRL_W;

  logic rst_ok;

  logic [DATA_W-1:0] acc_q   [LANES];
  logic [DATA_W-1:0] acc_d   [LANES];
  logic [LANES-1:0]  acc_en;
  logic [DATA_W-1:0] base_q  [BASES];
  logic [BASES-1:0]  base_en;
  ip_ctrl_t          ctrl_q  [LANES];
  ip_ctrl_t          ctrl_d;
  logic [LANES-1:0]  ctrl_en;

  logic [DATA_W-1:0] contrib [LANES];
  logic [DATA_W-1:0] res     [LANES];
  logic [DATA_W-1:0] view    [LANES];
  logic [DATA_W-1:0] full;

  logic [1:0]        acc_we;
  logic [2:0]        base_we;
  logic [1:0]        ctrl_we;
  logic              pop;

  interp_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ok (rst_ok)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    interp_lane #(
      .DATA_W    (DATA_W),
      .FORCE_LSB (FORCE_LSB)
    ) u_lane (
      .ctrl      (ctrl_q[k]),
      .acc_own   (acc_q[k]),
      .acc_other (acc_q[LANES-1-k]),
      .base      (base_q[k]),
      .contrib   (contrib[k]),
      .result    (res[k]),
      .bus_view  (view[k])
    );
  end

  assign full = base_q[LANES] + contrib[0] + contrib[1];

  interp_bus #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .CTRL_W (CTRL_W)
  ) u_bus (
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .acc0      (acc_q[0]),
    .acc1      (acc_q[1]),
    .base0     (base_q[0]),
    .base1     (base_q[1]),
    .base2     (base_q[2]),
    .ctrl0     (ctrl_q[0]),
    .ctrl1     (ctrl_q[1]),
    .view0     (view[0]),
    .view1     (view[1]),
    .full      (full),
    .acc_we    (acc_we),
    .base_we   (base_we),
    .ctrl_we   (ctrl_we),
    .pop       (pop),
    .rdata     (bus_rdata)
  );

  // next state and clock enables
  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      acc_en[k] = acc_we[k] | pop;
      if (acc_we[k]) begin
        acc_d[k] = bus_wdata;
      end else if (ctrl_q[k].cross_res) begin
        acc_d[k] = res[LANES-1-k];
      end else begin
        acc_d[k] = res[k];
      end
      ctrl_en[k] = ctrl_we[k];
    end
    for (int b = 0; b < BASES; b++) begin
      base_en[b] = base_we[b];
    end
    ctrl_d = ip_ctrl_t'(bus_wdata[CTRL_W-1:0]);
  end

  // state registers
  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      for (int k = 0; k < LANES; k++) begin
        acc_q[k]  <= '0;
        ctrl_q[k] <= '0;
      end
      for (int b = 0; b < BASES; b++) begin
        base_q[b] <= '0;
      end
    end else begin
      for (int k = 0; k < LANES; k++) begin
        if (acc_en[k])  acc_q[k]  <= acc_d[k];
        if (ctrl_en[k]) ctrl_q[k] <= ctrl_d;
      end
      for (int b = 0; b < BASES; b++) begin
        if (base_en[b]) base_q[b] <= bus_wdata;
      end
    end
  end

endmodule

// File: rtl/interp_unit_chk.sv
module interp_unit_chk
  import interp_pkg::*;
#(
  parameter int DATA_W    = IP_DATA_W,
  parameter int ADDR_W    = IP_ADDR_W,
  parameter int FORCE_LSB = 28
) (
  input logic              clk,
  input logic              rst_ok,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [DATA_W-1:0] acc0,
  input logic [DATA_W-1:0] acc1,
  input logic [DATA_W-1:0] base0,
  input ip_ctrl_t          ctrl0,
  input ip_ctrl_t          ctrl1,
  input logic [DATA_W-1:0] res0,
  input logic [DATA_W-1:0] res1,
  input logic [DATA_W-1:0] contrib0
);

  localparam logic [DATA_W-1:0] FMASK = DATA_W'(3) << FORCE_LSB;

  logic rd, is_pop, is_peek;
  assign rd      = bus_valid & ~bus_write;
  assign is_pop  = rd & ((bus_addr == ADDR_W'(ADR_POP0)) | (bus_addr == ADDR_W'(ADR_POP1)) |
                         (bus_addr == ADDR_W'(ADR_POPF)));
  assign is_peek = rd & ((bus_addr == ADDR_W'(ADR_PEEK0)) | (bus_addr == ADDR_W'(ADR_PEEK1)) |
                         (bus_addr == ADDR_W'(ADR_PEEKF)));

  AST_ACC_WRITE: assert property (@(posedge clk) disable iff (!rst_ok)
    (bus_valid && bus_write && bus_addr == ADDR_W'(ADR_ACC0)) |=> (acc0 == $past(bus_wdata))); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_ok)
    !bus_valid |=> ($stable(acc0) && $stable(acc1) && $stable(base0))); // R2

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_ok)
    !rd |-> (bus_rdata == '0)); // R2

  AST_PEEK_NO_SIDE: assert property (@(posedge clk) disable iff (!rst_ok)
    is_peek |=> ($stable(acc0) && $stable(acc1))); // R9

  AST_POP_WB0: assert property (@(posedge clk) disable iff (!rst_ok)
    is_pop |=> (acc0 == $past(ctrl0.cross_res ? res1 : res0))); // R10

  AST_POP_WB1: assert property (@(posedge clk) disable iff (!rst_ok)
    is_pop |=> (acc1 == $past(ctrl1.cross_res ? res0 : res1))); // R10

  AST_EMPTY_MASK: assert property (@(posedge clk) disable iff (!rst_ok)
    (ctrl0.msb < ctrl0.lsb) |-> (contrib0 == '0)); // R5

  AST_RAW_SUM: assert property (@(posedge clk) disable iff (!rst_ok)
    (ctrl0.add_raw && !ctrl0.cross_in) |-> (res0 == base0 + acc0)); // R6

  AST_FORCE_VIEW: assert property (@(posedge clk) disable iff (!rst_ok)
    (rd && bus_addr == ADDR_W'(ADR_PEEK0)) |-> ((bus_rdata & ~FMASK) == (res0 & ~FMASK))); // R12

endmodule

bind interp_unit interp_unit_chk #(
  .DATA_W    (DATA_W),
  .ADDR_W    (ADDR_W),
  .FORCE_LSB (FORCE_LSB)
) u_chk (
  .clk       (clk),
  .rst_ok    (rst_ok),
  .bus_valid (bus_valid),
  .bus_write (bus_write),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .acc0      (acc_q[0]),
  .acc1      (acc_q[1]),
  .base0     (base_q[0]),
  .ctrl0     (ctrl_q[0]),
  .ctrl1     (ctrl_q[1]),
  .res0      (res[0]),
  .res1      (res[1]),
  .contrib0  (contrib[0])
);

// File: tb/interp_unit_tb.sv
module interp_unit_tb_top;

  logic        clk;
  logic        rst_n;
  logic        bus_valid;
  logic        bus_write;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;

  int n_cmp;
  int n_bad;

  // behavioural model state
  logic [31:0] m_acc  [2];
  logic [31:0] m_base [3];
  logic [31:0] m_ctrl [2];

  interp_unit dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [31:0] m_src(int k);
    return m_ctrl[k][16] ? m_acc[1-k] : m_acc[k];
  endfunction

  function automatic logic [31:0] m_field(int k);
    logic [31:0] c;
    int sh, lo, hi;
    logic [63:0] v, keep;
    c  = m_ctrl[k];
    sh = int'(c[4:0]);
    lo = int'(c[9:5]);
    hi = int'(c[14:10]);
    if (hi < lo) return 32'h0;
    v    = {32'h0, m_src(k)} >> sh;
    keep = (64'd1 << (hi + 1)) - (64'd1 << lo);
    v    = v & keep;
    if (c[15] && v[hi]) v = v | ~((64'd1 << (hi + 1)) - 64'd1);
    return v[31:0];
  endfunction

  function automatic logic [31:0] m_res(int k);
    return m_base[k] + (m_ctrl[k][18] ? m_src(k) : m_field(k));
  endfunction

  function automatic logic [31:0] m_full();
    return m_base[2] + m_field(0) + m_field(1);
  endfunction

  function automatic logic [31:0] m_view(int k);
    return m_res(k) | ({30'h0, m_ctrl[k][20:19]} << 28);
  endfunction

  function automatic logic [31:0] m_read(logic [3:0] a);
    case (a)
      4'h0: return m_acc[0];
      4'h1: return m_acc[1];
      4'h2: return m_base[0];
      4'h3: return m_base[1];
      4'h4: return m_base[2];
      4'h5: return m_ctrl[0];
      4'h6: return m_ctrl[1];
      4'h8, 4'hC: return m_view(0);
      4'h9, 4'hD: return m_view(1);
      4'hA, 4'hE: return m_full();
      default: return 32'h0;
    endcase
  endfunction

  task automatic report;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // one bus cycle: drive at falling edge, compare, then advance model at rising edge
  task automatic xact(input bit wr, input logic [3:0] a, input logic [31:0] d, input string tag);
    logic [31:0] exp, r0, r1;
    logic [31:0] n_acc [2];
    @(negedge clk);
    bus_valid = 1'b1;
    bus_write = wr;
    bus_addr  = a;
    bus_wdata = d;
    #1;
    exp = wr ? 32'h0 : m_read(a);
    n_cmp++;
    if (bus_rdata !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%0h actual=%h expected=%h", tag, a, bus_rdata, exp);
    end
    r0 = m_res(0);
    r1 = m_res(1);
    n_acc[0] = m_acc[0];
    n_acc[1] = m_acc[1];
    if (!wr && (a == 4'hC || a == 4'hD || a == 4'hE)) begin
      n_acc[0] = m_ctrl[0][17] ? r1 : r0;
      n_acc[1] = m_ctrl[1][17] ? r0 : r1;
    end
    @(posedge clk);
    m_acc[0] = n_acc[0];
    m_acc[1] = n_acc[1];
    if (wr) begin
      case (a)
        4'h0: m_acc[0]  = d;
        4'h1: m_acc[1]  = d;
        4'h2: m_base[0] = d;
        4'h3: m_base[1] = d;
        4'h4: m_base[2] = d;
        4'h5: m_ctrl[0] = d & 32'h001F_FFFF;
        4'h6: m_ctrl[1] = d & 32'h001F_FFFF;
        default: ;
      endcase
    end
  endtask

  task automatic idle_check(input string tag);
    @(negedge clk);
    bus_valid = 1'b0;
    #1;
    n_cmp++;
    if (bus_rdata !== 32'h0) begin
      n_bad++;
      $display("FAIL %s idle actual=%h expected=00000000", tag, bus_rdata);
    end
  endtask

  function automatic logic [31:0] mkctrl(int sh, int lo, int hi, bit sgn, bit cin,
                                         bit cres, bit raw, int frc);
    return (32'(frc & 3) << 19) | (32'(raw) << 18) | (32'(cres) << 17) | (32'(cin) << 16) |
           (32'(sgn) << 15) | (32'(hi & 31) << 10) | (32'(lo & 31) << 5) | 32'(sh & 31);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    report();
    $finish;
  end

  initial begin
    n_cmp = 0;
    n_bad = 0;
    for (int k = 0; k < 2; k++) begin m_acc[k] = '0; m_ctrl[k] = '0; end
    for (int b = 0; b < 3; b++) m_base[b] = '0;
    rst_n = 1'b0; bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: reset state on every address
    for (int a = 0; a < 16; a++) xact(1'b0, 4'(a), 32'h0, "R1");

    // R2: write/readback, control width, ignored writes, idle read data
    xact(1'b1, 4'h0, 32'hDEAD_BEEF, "R2");
    xact(1'b0, 4'h0, 32'h0, "R2");
    xact(1'b1, 4'h5, 32'hFFFF_FFFF, "R2");
    xact(1'b0, 4'h5, 32'h0, "R2");
    xact(1'b1, 4'h8, 32'h1234_5678, "R2");
    xact(1'b1, 4'hF, 32'h1234_5678, "R2");
    xact(1'b0, 4'h0, 32'h0, "R2");
    xact(1'b0, 4'h7, 32'h0, "R2");
    idle_check("R2");

    // R3: shift 4, field bits 9..2
    xact(1'b1, 4'h5, mkctrl(4, 2, 9, 0, 0, 0, 0, 0), "R3");
    xact(1'b1, 4'h0, 32'h1234_5678, "R3");
    xact(1'b1, 4'h2, 32'h0000_0100, "R3");
    xact(1'b0, 4'h8, 32'h0, "R3");
    xact(1'b1, 4'h5, mkctrl(31, 0, 31, 0, 0, 0, 0, 0), "R3");
    xact(1'b0, 4'h8, 32'h0, "R3");

    // R4: sign extension from the high bound
    xact(1'b1, 4'h5, mkctrl(0, 0, 7, 1, 0, 0, 0, 0), "R4");
    xact(1'b1, 4'h0, 32'h0000_0080, "R4");
    xact(1'b0, 4'h8, 32'h0, "R4");
    xact(1'b1, 4'h0, 32'h0000_007F, "R4");
    xact(1'b0, 4'h8, 32'h0, "R4");

    // R5: inverted bounds contribute nothing
    xact(1'b1, 4'h5, mkctrl(0, 9, 3, 1, 0, 0, 0, 0), "R5");
    xact(1'b1, 4'h0, 32'hFFFF_FFFF, "R5");
    xact(1'b0, 4'h8, 32'h0, "R5");
    xact(1'b0, 4'hA, 32'h0, "R5");

    // R6: raw add for lane, FULL still masked
    xact(1'b1, 4'h5, mkctrl(8, 0, 3, 0, 0, 0, 1, 0), "R6");
    xact(1'b1, 4'h0, 32'h0000_0F55, "R6");
    xact(1'b0, 4'h8, 32'h0, "R6");
    xact(1'b0, 4'hA, 32'h0, "R6");

    // R7: cross input, also under raw add
    xact(1'b1, 4'h1, 32'hABCD_0123, "R7");
    xact(1'b1, 4'h6, mkctrl(4, 0, 7, 0, 1, 0, 0, 0), "R7");
    xact(1'b0, 4'h9, 32'h0, "R7");
    xact(1'b1, 4'h5, mkctrl(0, 0, 3, 0, 1, 0, 1, 0), "R7");
    xact(1'b0, 4'h8, 32'h0, "R7");

    // R8: combined result
    xact(1'b1, 4'h4, 32'h1000_0000, "R8");
    xact(1'b1, 4'h5, mkctrl(0, 0, 15, 0, 0, 0, 0, 0), "R8");
    xact(1'b0, 4'hA, 32'h0, "R8");

    // R9: peek leaves state untouched
    xact(1'b0, 4'h8, 32'h0, "R9");
    xact(1'b0, 4'h9, 32'h0, "R9");
    xact(1'b0, 4'h0, 32'h0, "R9");
    xact(1'b0, 4'h1, 32'h0, "R9");

    // R10: pops, plain and crossed, back to back
    xact(1'b0, 4'hC, 32'h0, "R10");
    xact(1'b0, 4'h0, 32'h0, "R10");
    xact(1'b0, 4'h1, 32'h0, "R10");
    xact(1'b1, 4'h5, mkctrl(0, 0, 31, 0, 0, 1, 0, 0), "R10");
    xact(1'b1, 4'h6, mkctrl(0, 0, 31, 0, 0, 1, 0, 0), "R10");
    xact(1'b0, 4'hD, 32'h0, "R10");
    xact(1'b0, 4'hD, 32'h0, "R10");
    xact(1'b0, 4'h0, 32'h0, "R10");
    xact(1'b0, 4'h1, 32'h0, "R10");

    // R11: pop through the combined address
    xact(1'b0, 4'hE, 32'h0, "R11");
    xact(1'b0, 4'h0, 32'h0, "R11");
    xact(1'b0, 4'h1, 32'h0, "R11");

    // R12: forced bits on the bus only
    xact(1'b1, 4'h5, mkctrl(0, 0, 31, 0, 0, 0, 0, 3), "R12");
    xact(1'b1, 4'h0, 32'h0000_0010, "R12");
    xact(1'b1, 4'h2, 32'h0000_0001, "R12");
    xact(1'b0, 4'h8, 32'h0, "R12");
    xact(1'b0, 4'hC, 32'h0, "R12");
    xact(1'b0, 4'h0, 32'h0, "R12");

    // mixed traffic, model compared every cycle
    for (int i = 0; i < 1500; i++) begin
      logic [3:0]  a;
      logic [31:0] d;
      bit          wr;
      a  = 4'($urandom_range(0, 15));
      d  = $urandom();
      wr = ($urandom_range(0, 2) == 0);
      if (wr && (a == 4'h5 || a == 4'h6)) d = d & 32'h001F_FFFF;
      if (i % 97 == 0) idle_check("R2");
      else xact(wr, a, d, "R3");
    end

    report();
    $finish;
  end

endmodule